// File: doc/BRIEF.md
# Static Re-Reference Prediction Replacement Controller

This block picks replacement victims for a set-associative cache. For every way of every set it keeps a small counter that predicts how soon the line will be used again: zero means very soon, and the all-ones value means far in the future. A cache controller sends one request per lookup. The request names the set, says whether the lookup hit and, on a hit, names the way. The block reads that set's row of counters from a single-port array and computes the new row. It then writes the row back and answers with the way it touched.

On a hit the counter of the hit way is refreshed. A parameter selects one of two update rules: clear the counter to zero, or lower it by one. On a miss the block looks for the lowest-numbered way whose counter is at its maximum. If no counter in the set is at the maximum, all counters in the set are raised by one and the search runs again. The chosen way is reported as the victim. Its counter is set one below the maximum, so a newly filled line is predicted to be reused late, but not as late as the lines already at the maximum. The block handles one request at a time. While a request is in progress the block raises `busy`.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After reset the block writes the maximum value (2^M-1) into every counter of every set, one set per cycle. `busy` is high for exactly SETS cycles after reset is released and `done` stays low. Afterwards, the first miss in any set selects way 0 with no aging round.
- R2: With FREQ_PRIO=0, a hit sets the hit way's counter to 0 and leaves the other ways unchanged.
- R3: With FREQ_PRIO=1, a hit lowers the hit way's counter by one, stopping at 0, and leaves the other ways unchanged.
- R4: On a miss the victim is the lowest-indexed way whose counter equals 2^M-1.
- R5: When no way in the set is at 2^M-1, every counter in the set is raised by one and the search repeats. There are never more than 2^M-1 aging rounds, and no counter goes past 2^M-1.
- R6: The victim's counter is written as 2^M-2. The other counters in the set keep their aged values.
- R7: `done` is a one-cycle pulse, and `victim_way` is valid in that cycle. On a hit `victim_way` equals the hit way. Counting the edge that accepts the request as edge 1, `done` rises after edge 4+k, where k is the number of aging rounds (k=0 for a hit).
- R8: `busy` is high from the edge after the request is accepted until the cycle in which `done` is high. A request presented while `busy` is high is ignored and changes no counter.
- R9: `busy` is low in the cycle in which `done` is high, and a new request may be accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the array fill |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_set | input | $clog2(SETS) | Set index of the request |
| req_hit | input | 1 | 1 = lookup hit, 0 = miss |
| req_way | input | $clog2(WAYS) | Hit way (ignored on a miss) |
| victim_way | output | $clog2(WAYS) | Victim way on a miss, hit way on a hit |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Fill or request in progress |

## Verification
Some properties are checked by assertions on every cycle:
- a reported victim always holds the maximum value, and no lower-indexed way does;
- the aging count never exceeds 2^M-1;
- a hit finishes with no aging round;
- `done` is a single pulse and never overlaps `busy`;
- the latched request does not change while `busy` is high.

Other behaviour can only be shown by the bench's request sequences, checked against a reference model:
- the hit update under each priority rule, including the stop at zero;
- the insertion value;
- the exact latency for each number of aging rounds;
- that a request presented while `busy` is high leaves no trace in later victim choices.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  typedef enum logic [2:0] {
    ST_FILL,
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_SCAN
  } rrip_state_e;
endpackage

// File: rtl/rrip_row_mem.sv
module rrip_row_mem #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // One port: a cycle either writes or reads, never both.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
  parameter int WAYS = 16,
  parameter int M    = 2,
  localparam int WAY_W = $clog2(WAYS),
  localparam int ROW_W = WAYS * M
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  output logic             found,
  output logic [WAY_W-1:0] vic,
  output logic [ROW_W-1:0] aged
);
  localparam logic [M-1:0] MAXV = {M{1'b1}};

  logic [WAYS-1:0] at_max;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign at_max[g] = (row[g*M +: M] == MAXV);
    // The aged row is used only when no way is at the maximum; it still saturates.
    assign aged[g*M +: M] = at_max[g] ? MAXV : row[g*M +: M] + M'(1);
  end

  always_comb begin
    found = |at_max;
    vic   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (at_max[i]) vic = WAY_W'(i);
    end
  end

  logic [WAYS-1:0] below_vic;
  assign below_vic = ({{(WAYS-1){1'b0}}, 1'b1} << vic) - {{(WAYS-1){1'b0}}, 1'b1};

  // R4: the reported way holds the maximum value.
  p_victim_is_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (row[vic*M +: M] == MAXV));
  // R4: no lower-indexed way holds the maximum value.
  p_first_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((at_max & below_vic) == '0));
endmodule

// File: rtl/rrip_repl_ctrl.sv
module rrip_repl_ctrl
  import rrip_pkg::*;
#(
  parameter int WAYS      = 16,
  parameter int SETS      = 2048,
  parameter int M         = 2,
  parameter bit FREQ_PRIO = 1'b0,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int ROW_W = WAYS * M,
  localparam int AGE_W = M + 1,
  localparam int MAX_I = (1 << M) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_way,
  output logic [WAY_W-1:0] victim_way,
  output logic             done,
  output logic             busy
);
  localparam logic [M-1:0] MAXV = {M{1'b1}};

  function automatic logic [M-1:0] hit_next(input logic [M-1:0] v);
    if (FREQ_PRIO) return (v == '0) ? '0 : v - M'(1);
    else           return '0;
  endfunction

  rrip_state_e      state;
  logic [SET_W-1:0] fill_idx, set_q;
  logic             hit_q, done_q;
  logic [WAY_W-1:0] way_q, victim_q;
  logic [ROW_W-1:0] work_q, rdata, wdata, hit_row, ins_row, aged;
  logic [AGE_W-1:0] age_q;
  logic             found, mem_en, mem_we;
  logic [WAY_W-1:0] vic;
  logic [SET_W-1:0] mem_addr;

  // Named internal events.
  logic accept, finish, age_step;
  assign accept   = (state == ST_IDLE) && req_valid;
  assign finish   = (state == ST_SCAN) && (hit_q || found);
  assign age_step = (state == ST_SCAN) && !hit_q && !found;

  rrip_row_mem #(.DEPTH(SETS), .WIDTH(ROW_W)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(wdata), .rdata(rdata)
  );

  rrip_victim_pick #(.WAYS(WAYS), .M(M)) u_pick (
    .clk(clk), .rst_n(rst_n), .row(work_q),
    .found(found), .vic(vic), .aged(aged)
  );

  always_comb begin
    hit_row = work_q;
    hit_row[way_q*M +: M] = hit_next(work_q[way_q*M +: M]);
    ins_row = work_q;
    ins_row[vic*M +: M] = MAXV - M'(1);
  end

  always_comb begin
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = set_q;
    wdata    = hit_q ? hit_row : ins_row;
    unique case (state)
      ST_FILL: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = fill_idx; wdata = {WAYS{MAXV}};
      end
      ST_READ: mem_en = 1'b1;
      ST_SCAN: begin mem_en = finish; mem_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      fill_idx <= '0;
      set_q    <= '0;
      hit_q    <= 1'b0;
      way_q    <= '0;
      work_q   <= '0;
      age_q    <= '0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_FILL: begin
          fill_idx <= fill_idx + SET_W'(1);
          if (fill_idx == SET_W'(SETS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: if (accept) begin
          set_q <= req_set;
          hit_q <= req_hit;
          way_q <= req_way;
          age_q <= '0;
          state <= ST_READ;
        end
        ST_READ: state <= ST_LOAD;
        ST_LOAD: begin work_q <= rdata; state <= ST_SCAN; end
        ST_SCAN: begin
          if (finish) begin
            done_q   <= 1'b1;
            victim_q <= hit_q ? way_q : vic;
            state    <= ST_IDLE;
          end else begin
            work_q <= aged;
            age_q  <= age_q + AGE_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign victim_way = victim_q;

  p_age_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN) |-> (age_q <= AGE_W'(MAX_I)));
  p_hit_no_aging_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && hit_q) |-> (age_q == '0));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && state != ST_FILL) |=> ($stable(set_q) && $stable(hit_q) && $stable(way_q)));
endmodule

// File: tb/tb_rrip_repl_ctrl.sv
`timescale 1ns/1ps
module tb_rrip_repl_ctrl;
  localparam int WAYS = 4;
  localparam int SETS = 4;
  localparam int M    = 2;
  localparam int WW   = $clog2(WAYS);
  localparam int SW   = $clog2(SETS);
  localparam int MAXR = (1 << M) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [SW-1:0] req_set = '0;
  logic req_hit = 1'b0;
  logic [WW-1:0] req_way = '0;
  logic [WW-1:0] vh, vf;
  logic dh, df, bh, bf;

  always #10 clk = ~clk;

  rrip_repl_ctrl #(.WAYS(WAYS), .SETS(SETS), .M(M), .FREQ_PRIO(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
    .req_hit(req_hit), .req_way(req_way), .victim_way(vh), .done(dh), .busy(bh));

  rrip_repl_ctrl #(.WAYS(WAYS), .SETS(SETS), .M(M), .FREQ_PRIO(1'b1)) dut_fp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
    .req_hit(req_hit), .req_way(req_way), .victim_way(vf), .done(df), .busy(bf));

  int compared = 0;
  int mismatched = 0;
  int mh [SETS][WAYS];
  int mf [SETS][WAYS];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_op(input bit fp, input int s, input bit hit, input int w,
                          output int vic, output int ages);
    int r [WAYS];
    for (int i = 0; i < WAYS; i++) r[i] = fp ? mf[s][i] : mh[s][i];
    ages = 0;
    vic  = w;
    if (hit) begin
      r[w] = fp ? ((r[w] > 0) ? r[w] - 1 : 0) : 0;
    end else begin
      vic = -1;
      while (vic < 0) begin
        for (int i = WAYS - 1; i >= 0; i--) if (r[i] == MAXR) vic = i;
        if (vic < 0) begin
          ages++;
          for (int i = 0; i < WAYS; i++) r[i] = r[i] + 1;
        end
      end
      r[vic] = MAXR - 1;
    end
    for (int i = 0; i < WAYS; i++) begin
      if (fp) mf[s][i] = r[i];
      else    mh[s][i] = r[i];
    end
  endtask

  // Called at a negedge with both instances idle.
  task automatic do_op(input int s, input bit hit, input int w, input string tag, input bit poke);
    int eh_v, eh_a, ef_v, ef_a, cyc, th, tf, gh, gf;
    model_op(1'b0, s, hit, w, eh_v, eh_a);
    model_op(1'b1, s, hit, w, ef_v, ef_a);
    req_valid = 1'b1;
    req_set   = SW'(s);
    req_hit   = hit;
    req_way   = WW'(w);
    @(posedge clk);
    @(negedge clk);
    check(bh && bf, {tag, " R8 busy after accept"}, int'(bh) + int'(bf), 2);
    if (poke) begin
      // R8: a second request while busy, to another set, must be dropped.
      req_set = SW'((s + 1) % SETS);
      req_hit = 1'b0;
    end else begin
      req_valid = 1'b0;
    end
    cyc = 1; th = 0; tf = 0; gh = 0; gf = 0;
    while ((th == 0 || tf == 0) && cyc < 40) begin
      if (dh && th == 0) begin
        th = cyc; gh = int'(vh);
        check(!bh, {tag, " R9 busy low with done"}, int'(bh), 0);
      end
      if (df && tf == 0) begin
        tf = cyc; gf = int'(vf);
        check(!bf, {tag, " R9 busy low with done"}, int'(bf), 0);
      end
      if (th == 0 || tf == 0) begin
        @(negedge clk);
        cyc++;
        if (cyc == 2) req_valid = 1'b0;
      end
    end
    check(th == 4 + eh_a, {tag, " R7 latency (clear on hit)"}, th, 4 + eh_a);
    check(gh == eh_v, {tag, " R4 R6 way (clear on hit)"}, gh, eh_v);
    check(tf == 4 + ef_a, {tag, " R7 latency (decrement on hit)"}, tf, 4 + ef_a);
    check(gf == ef_v, {tag, " R4 R6 way (decrement on hit)"}, gf, ef_v);
  endtask

  initial begin
    #(20 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n, s, w;
    bit h;
    for (int i = 0; i < SETS; i++)
      for (int j = 0; j < WAYS; j++) begin
        mh[i][j] = MAXR;
        mf[i][j] = MAXR;
      end
    repeat (3) @(negedge clk);
    check(bh && bf && !dh && !df, "R1 busy during reset, done low", int'(bh) + int'(dh), 1);
    rst_n = 1'b1;
    n = 0;
    while (bh && n < 100) begin
      @(negedge clk);
      n++;
      if (dh || df) check(1'b0, "R1 done during fill", 1, 0);
    end
    check(n == SETS, "R1 fill length", n, SETS);

    // R1 R4 R6: fill every set from way 0 upward.
    for (int i = 0; i < SETS; i++)
      for (int j = 0; j < WAYS; j++) do_op(i, 1'b0, 0, "R1 R4 R6 fill", 1'b0);

    // R2 R3: repeated hits on one way, then misses that reveal its value.
    do_op(0, 1'b1, 2, "R2 R3 hit", 1'b0);
    do_op(0, 1'b1, 2, "R2 R3 hit", 1'b0);
    do_op(0, 1'b1, 2, "R3 saturate at zero", 1'b0);
    for (int k = 0; k < 5; k++) do_op(0, 1'b0, 0, "R5 R6 miss after hits", 1'b0);

    // R5: every way hit, then a miss needs the most aging rounds.
    for (int j = 0; j < WAYS; j++) do_op(1, 1'b1, j, "R2 R3 hit all", 1'b0);
    do_op(1, 1'b0, 0, "R5 worst aging", 1'b0);
    do_op(1, 1'b0, 0, "R5 after aging", 1'b0);

    // R8: requests presented while busy are dropped.
    for (int k = 0; k < 6; k++) do_op(2, 1'b0, 0, "R8 poke while busy", 1'b1);
    for (int k = 0; k < 4; k++) do_op(3, 1'b0, 0, "R8 set left untouched", 1'b0);

    // Mixed sweep.
    for (int k = 0; k < 400; k++) begin
      s = $urandom_range(SETS - 1);
      w = $urandom_range(WAYS - 1);
      h = ($urandom_range(2) == 0);
      do_op(s, h, w, "R2 R3 R4 R5 R6 mixed", (k % 7) == 0);
    end

    @(negedge clk);
    check(!bh && !bf && !dh && !df, "R7 R9 idle at end", int'(bh) + int'(dh), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule